// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block handles the receive half of a small USB device with up to three endpoints. A token decoder upstream presents each OUT or SETUP token with its 4-bit endpoint number, and a packet receiver then presents the data packet's PID (DATA0 or DATA1) and whether its CRC was good. The controller routes the token to an endpoint, decides the handshake (ACK, NAK, STALL, or silence) and updates that endpoint's expected data toggle and receive status. When a transfer completes correctly, it raises a one-cycle correct-transfer pulse for that endpoint.

Software owns one 8-bit receive control register per endpoint, accessed through a simple write strobe and a combinational read mux. After each completed transfer the hardware parks the endpoint at NAK, so firmware has time to drain the received data before it re-arms the endpoint. Endpoint 0 is always a control endpoint with fixed endpoint number 0. Any other endpoint can also be made a control endpoint.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: For an OUT data packet with good CRC on a routed endpoint, the 2-bit receive status selects the reply: 2'b00 (off) gives no handshake, 2'b01 gives STALL, 2'b10 gives NAK, and 2'b11 gives ACK. On `hs_code` the values are ACK=2'b00, NAK=2'b01 and STALL=2'b10.
- R2: The toggle bit (register bit 6, 0=DATA0, 1=DATA1) inverts only when a packet is accepted whose PID equals the toggle.
- R3: A SETUP token routed to a control endpoint clears that endpoint's toggle in the cycle after the token.
- R4: An accepted transfer sets the endpoint's status to 2'b10. It also drives `ctr` one-hot, with the bit equal to the endpoint index, for one cycle together with `hs_valid` and ACK. Both appear in the cycle after the packet strobe.
- R5: A token is routed to the lowest-indexed endpoint whose status is not 2'b00 and whose register bits 3:0 equal the token's endpoint number.
- R6: The register layout is: bit 7 control flag, bit 6 toggle, bits 5:4 status, bits 3:0 endpoint number. Endpoints 1 and 2 reset to 0x00, and writes store all eight bits.
- R7: Endpoint 0 reads bit 7 as 1 and bits 3:0 as 0 whatever is written, and it resets to 0x80.
- R8: A one-cycle `bus_reset` returns every register to its reset value, the same as `rst_n`.
- R9: A packet with a bad CRC, or a token that routes to no endpoint, produces no handshake and changes no register.
- R10: On a status-2'b11 endpoint, a good packet whose PID differs from the toggle is ACKed. The toggle and status are left unchanged, and `ctr` stays 0.
- R11: A SETUP on a control endpoint is ACKed and accepted whenever the endpoint's status is not 2'b00, including STALL and NAK.
- R12: The control flag (bit 7) makes any endpoint accept SETUP. A SETUP on an endpoint without the flag gets no handshake and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_reset | input | 1 | USB bus reset, synchronous, one cycle |
| tok_valid | input | 1 | Token strobe |
| tok_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep | input | 4 | Token endpoint number |
| pkt_valid | input | 1 | Data packet strobe |
| pkt_pid1 | input | 1 | 1 = DATA1, 0 = DATA0 |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (endpoint index) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | Handshake type |
| ctr | output | 3 | Correct-transfer pulse per endpoint |

## Verification
A wrong toggle or status inside an endpoint shows at the ports in two ways. The register readback shows it at once. The handshake for the next packet shows it one cycle after that packet: NAK instead of ACK, or an ACK with no `ctr` pulse. For this reason every transaction is followed by a readback of the affected register. The bench also checks every cycle where no reply is expected, so a handshake raised for a bad-CRC packet, an unrouted token or a SETUP to a plain endpoint is caught in the cycle it appears.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

   typedef enum logic [1:0] {
      ST_OFF   = 2'b00,
      ST_STALL = 2'b01,
      ST_NAK   = 2'b10,
      ST_VALID = 2'b11
   } rx_stat_e;

   typedef enum logic [1:0] {
      HS_ACK   = 2'b00,
      HS_NAK   = 2'b01,
      HS_STALL = 2'b10
   } hs_e;

   // Bit layout is fixed: a neighbouring register block decodes it.
   typedef struct packed {
      logic       ctrl;
      logic       tog;
      rx_stat_e   stat;
      logic [3:0] epnum;
   } ep_reg_t;

endpackage

// File: rtl/usb_rx_ep_reg.sv
module usb_rx_ep_reg
   import usb_rx_ep_pkg::*;
#(
   parameter bit IS_EP0 = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_reset,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       tog_clr,
   input  logic       accept,
   output ep_reg_t    q
);

   localparam ep_reg_t RST_VAL = IS_EP0 ? ep_reg_t'(8'h80) : ep_reg_t'(8'h00);

   ep_reg_t wr_val;

   generate
      if (IS_EP0) begin : g_fixed
         always_comb begin
            wr_val       = ep_reg_t'(wdata);
            wr_val.ctrl  = 1'b1;
            wr_val.epnum = 4'h0;
         end
      end else begin : g_free
         always_comb wr_val = ep_reg_t'(wdata);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (bus_reset) begin
         q <= RST_VAL;
      end else if (accept) begin
         q.tog  <= ~q.tog;
         q.stat <= ST_NAK;
      end else if (tog_clr) begin
         q.tog <= 1'b0;
      end else if (wr_en) begin
         q <= wr_val;
      end
   end

   AST_ACCEPT_PARKS_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !bus_reset |=> q.stat == ST_NAK); // R4
   AST_TOGGLE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !bus_reset |=> q.tog != $past(q.tog)); // R2
   AST_SETUP_CLEARS_TOG: assert property (@(posedge clk) disable iff (!rst_n)
      tog_clr && !accept && !bus_reset |=> !q.tog); // R3
   AST_BUS_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> q.stat == ST_OFF && !q.tog); // R8

endmodule

// File: rtl/usb_rx_ep_match.sv
module usb_rx_ep_match #(
   parameter int NUM_EP = 3,
   parameter int EPN_W  = 4,
   parameter int IW     = 2
) (
   input  logic [EPN_W-1:0]             tok_ep,
   input  logic [NUM_EP-1:0][EPN_W-1:0] ep_num,
   input  logic [NUM_EP-1:0]            ep_on,
   output logic                         hit,
   output logic [IW-1:0]                idx
);

   // Scan downwards so the lowest matching index is the one left standing.
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_EP - 1; i >= 0; i--) begin
         if (ep_on[i] && ep_num[i] == tok_ep) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/usb_rx_ep_resp.sv
module usb_rx_ep_resp
   import usb_rx_ep_pkg::*;
#(
   parameter int NUM_EP = 3,
   parameter int IW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              pkt_valid,
   input  logic              pkt_pid1,
   input  logic              pkt_crc_ok,
   input  logic              pend_vld,
   input  logic              pend_setup,
   input  logic [IW-1:0]     pend_idx,
   input  logic              sel_ctrl,
   input  logic              sel_tog,
   input  rx_stat_e          sel_stat,
   output logic [NUM_EP-1:0] accept_vec,
   output logic              hs_valid,
   output logic [1:0]        hs_code,
   output logic [NUM_EP-1:0] ctr
);

   logic pkt_ok;
   logic hv_d;
   hs_e  code_d;
   logic acc_d;

   assign pkt_ok = pkt_valid && pend_vld && pkt_crc_ok;

   always_comb begin
      hv_d   = 1'b0;
      code_d = HS_ACK;
      acc_d  = 1'b0;
      if (pkt_ok) begin
         if (pend_setup) begin
            if (sel_ctrl && sel_stat != ST_OFF) begin
               hv_d  = 1'b1;
               acc_d = (pkt_pid1 == sel_tog);
            end
         end else begin
            unique case (sel_stat)
               ST_STALL: begin hv_d = 1'b1; code_d = HS_STALL; end
               ST_NAK:   begin hv_d = 1'b1; code_d = HS_NAK;   end
               ST_VALID: begin hv_d = 1'b1; acc_d = (pkt_pid1 == sel_tog); end
               default:  hv_d = 1'b0;
            endcase
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_EP; i++) begin
         accept_vec[i] = acc_d && (pend_idx == IW'(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_ACK;
         ctr      <= '0;
      end else if (bus_reset) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_ACK;
         ctr      <= '0;
      end else begin
         hs_valid <= hv_d;
         hs_code  <= code_d;
         ctr      <= accept_vec;
      end
   end

   AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && !pkt_crc_ok |=> !hs_valid); // R9
   AST_STALL_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ok && !pend_setup && sel_stat == ST_STALL && !bus_reset
      |=> hs_valid && hs_code == HS_STALL); // R1
   AST_CTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctr)); // R4
   AST_CTR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ctr != '0 |-> hs_valid && hs_code == HS_ACK); // R4
   AST_SETUP_PLAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ok && pend_setup && !sel_ctrl |=> !hs_valid); // R12

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
   import usb_rx_ep_pkg::*;
#(
   parameter int NUM_EP = 3,
   parameter int EPN_W  = 4,
   parameter int DW     = 8,
   localparam int IW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              tok_valid,
   input  logic              tok_setup,
   input  logic [EPN_W-1:0]  tok_ep,
   input  logic              pkt_valid,
   input  logic              pkt_pid1,
   input  logic              pkt_crc_ok,
   input  logic              reg_wr,
   input  logic [IW-1:0]     reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              hs_valid,
   output logic [1:0]        hs_code,
   output logic [NUM_EP-1:0] ctr
);

   generate
      if (NUM_EP < 1 || NUM_EP > (1 << EPN_W)) begin : g_bad_num_ep
         $error("usb_rx_ep_ctrl: NUM_EP out of range");
      end
      if (EPN_W != 4 || DW != 8) begin : g_bad_width
         $error("usb_rx_ep_ctrl: register layout needs EPN_W=4 and DW=8");
      end
   endgenerate

   ep_reg_t                       regs [NUM_EP];
   logic [NUM_EP-1:0][EPN_W-1:0]  ep_num;
   logic [NUM_EP-1:0]             ep_on;
   logic [NUM_EP-1:0]             accept_vec;
   logic                          hit;
   logic [IW-1:0]                 hit_idx;

   logic                          pend_vld;
   logic                          pend_setup;
   logic [IW-1:0]                 pend_idx;
   ep_reg_t                       sel;

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         logic clr_i;
         assign clr_i = tok_valid && tok_setup && hit && hit_idx == IW'(i) && regs[i].ctrl;

         usb_rx_ep_reg #(.IS_EP0(i == 0)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_reset (bus_reset),
            .wr_en     (reg_wr && reg_addr == IW'(i)),
            .wdata     (reg_wdata),
            .tog_clr   (clr_i),
            .accept    (accept_vec[i]),
            .q         (regs[i])
         );

         assign ep_num[i] = regs[i].epnum;
         assign ep_on[i]  = regs[i].stat != ST_OFF;
      end
   endgenerate

   usb_rx_ep_match #(.NUM_EP(NUM_EP), .EPN_W(EPN_W), .IW(IW)) u_match (
      .tok_ep (tok_ep),
      .ep_num (ep_num),
      .ep_on  (ep_on),
      .hit    (hit),
      .idx    (hit_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld   <= 1'b0;
         pend_setup <= 1'b0;
         pend_idx   <= '0;
      end else if (bus_reset) begin
         pend_vld   <= 1'b0;
         pend_setup <= 1'b0;
         pend_idx   <= '0;
      end else if (tok_valid) begin
         pend_vld   <= hit;
         pend_setup <= tok_setup;
         pend_idx   <= hit_idx;
      end else if (pkt_valid) begin
         pend_vld   <= 1'b0;
      end
   end

   always_comb begin
      sel       = '0;
      reg_rdata = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (pend_idx == IW'(i)) sel = regs[i];
         if (reg_addr == IW'(i)) reg_rdata = regs[i];
      end
   end

   usb_rx_ep_resp #(.NUM_EP(NUM_EP), .IW(IW)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_reset  (bus_reset),
      .pkt_valid  (pkt_valid),
      .pkt_pid1   (pkt_pid1),
      .pkt_crc_ok (pkt_crc_ok),
      .pend_vld   (pend_vld),
      .pend_setup (pend_setup),
      .pend_idx   (pend_idx),
      .sel_ctrl   (sel.ctrl),
      .sel_tog    (sel.tog),
      .sel_stat   (sel.stat),
      .accept_vec (accept_vec),
      .hs_valid   (hs_valid),
      .hs_code    (hs_code),
      .ctr        (ctr)
   );

   AST_UNROUTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && !hit && !bus_reset |=> !pend_vld); // R9

endmodule

// File: tb/usb_rx_ep_ctrl_test.sv
module usb_rx_ep_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NEP = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_reset = 1'b0;
   logic       tok_valid = 1'b0;
   logic       tok_setup = 1'b0;
   logic [3:0] tok_ep = '0;
   logic       pkt_valid = 1'b0;
   logic       pkt_pid1 = 1'b0;
   logic       pkt_crc_ok = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       hs_valid;
   logic [1:0] hs_code;
   logic [NEP-1:0] ctr;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int             due;
      logic           hv;
      logic [1:0]     code;
      logic [NEP-1:0] ctr;
      string          req;
   } exp_t;
   exp_t sb[$];

   usb_rx_ep_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
      .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep),
      .pkt_valid(pkt_valid), .pkt_pid1(pkt_pid1), .pkt_crc_ok(pkt_crc_ok),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .hs_valid(hs_valid), .hs_code(hs_code), .ctr(ctr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare due items, and require silence on every other cycle.
   initial begin
      forever begin
         @(negedge clk);
         if (running) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
               exp_t e;
               e = sb.pop_front();
               checks++;
               if (hs_valid !== e.hv || (e.hv && hs_code !== e.code) || ctr !== e.ctr) begin
                  failures++;
                  $display("FAIL %s: hs_valid=%0b hs_code=%0d ctr=%b expected hs_valid=%0b hs_code=%0d ctr=%b",
                           e.req, hs_valid, hs_code, ctr, e.hv, e.code, e.ctr);
               end
            end else if (hs_valid !== 1'b0 || ctr !== '0) begin
               checks++;
               failures++;
               $display("FAIL R9: unexpected hs_valid=%0b ctr=%b expected hs_valid=0 ctr=000",
                        hs_valid, ctr);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         failures++;
         $display("FAIL %s: reg[%0d]=%h expected %h", req, a, reg_rdata, exp);
      end
   endtask

   // Driver: token cycle, packet cycle, expected reply pushed for the cycle after.
   task automatic xfer(input logic setup, input logic [3:0] ep, input logic pid1,
                       input logic crc, input logic hv, input logic [1:0] code,
                       input logic [NEP-1:0] c, input string req);
      exp_t e;
      @(negedge clk);
      tok_valid = 1'b1; tok_setup = setup; tok_ep = ep;
      @(negedge clk);
      tok_valid = 1'b0;
      pkt_valid = 1'b1; pkt_pid1 = pid1; pkt_crc_ok = crc;
      e.due = cyc + 1; e.hv = hv; e.code = code; e.ctr = c; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STL = 2'b10;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      running = 1'b1;

      rd_check(0, 8'h80, "R7 reset");
      rd_check(1, 8'h00, "R6 reset");
      rd_check(2, 8'h00, "R6 reset");

      wr(0, 8'h35);
      rd_check(0, 8'hB0, "R7 forced bits");
      wr(1, 8'h31);
      wr(2, 8'h22);
      rd_check(1, 8'h31, "R6 write");

      xfer(0, 4'd1, 0, 1, 1, ACK, 3'b010, "R4 accept ep1");
      rd_check(1, 8'h61, "R2 R4 toggle and NAK");
      xfer(0, 4'd1, 1, 1, 1, NAK, 3'b000, "R1 NAK");
      rd_check(1, 8'h61, "R1 NAK no change");

      wr(1, 8'h71);
      xfer(0, 4'd1, 0, 1, 1, ACK, 3'b000, "R10 pid mismatch");
      rd_check(1, 8'h71, "R10 state kept");
      xfer(0, 4'd1, 1, 1, 1, ACK, 3'b010, "R2 DATA1 accept");
      rd_check(1, 8'h21, "R2 toggle back to 0");

      wr(1, 8'h31);
      xfer(0, 4'd1, 0, 0, 0, ACK, 3'b000, "R9 bad CRC");
      rd_check(1, 8'h31, "R9 bad CRC no change");
      xfer(0, 4'd5, 0, 1, 0, ACK, 3'b000, "R5 R9 unrouted");
      rd_check(1, 8'h31, "R9 unrouted no change");

      xfer(0, 4'd2, 0, 1, 1, NAK, 3'b000, "R1 NAK ep2");
      wr(2, 8'h12);
      xfer(0, 4'd2, 0, 1, 1, STL, 3'b000, "R1 STALL ep2");

      xfer(1, 4'd1, 0, 1, 0, ACK, 3'b000, "R12 SETUP plain ep");
      rd_check(1, 8'h31, "R12 no change");

      wr(0, 8'h70);
      rd_check(0, 8'hF0, "R7 ep0 write");
      xfer(1, 4'd0, 0, 1, 1, ACK, 3'b001, "R3 R11 SETUP ep0");
      rd_check(0, 8'hE0, "R3 R4 ep0 after SETUP");
      xfer(1, 4'd0, 0, 1, 1, ACK, 3'b001, "R11 SETUP while NAK");
      rd_check(0, 8'hE0, "R11 ep0 after second SETUP");

      wr(0, 8'h10);
      xfer(0, 4'd0, 0, 1, 1, STL, 3'b000, "R1 STALL ep0");
      xfer(1, 4'd0, 0, 1, 1, ACK, 3'b001, "R11 SETUP while STALL");
      rd_check(0, 8'hE0, "R11 ep0 after STALL SETUP");

      wr(1, 8'h01);
      xfer(0, 4'd1, 0, 1, 0, ACK, 3'b000, "R1 off endpoint");

      wr(2, 8'hD2);
      xfer(1, 4'd2, 0, 1, 1, ACK, 3'b100, "R12 control ep2");
      rd_check(2, 8'hE2, "R12 ep2 after SETUP");

      @(negedge clk);
      bus_reset = 1'b1;
      @(negedge clk);
      bus_reset = 1'b0;
      rd_check(0, 8'h80, "R8 bus reset ep0");
      rd_check(1, 8'h00, "R8 bus reset ep1");
      rd_check(2, 8'h00, "R8 bus reset ep2");
      xfer(0, 4'd0, 0, 1, 0, ACK, 3'b000, "R8 ep0 off after bus reset");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R4: %0d replies never checked expected 0", sb.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule